// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block is the control state machine of a boost power stage. Once an active-low enable is asserted, it takes the stage through a timed start-up. First the input switch acts as a current-limited source that pre-charges the output. Next the input switch is fully closed. Then come three soft boost stages, in which the switching driver runs with its peak current limit scaled to a quarter, a half and three quarters of full. Last is normal regulation at full limit. Every stage length is a count of timebase ticks, which normally arrive at 1 MHz.

Digital fault flags from analog detectors are watched continuously, and each class of fault has its own reaction. Supply undervoltage shuts everything off until the supply-on flag returns. Input-switch overcurrent restarts the sequence at once. Output overvoltage and over-temperature open the power path and hold it open until their own release flag is seen. Every restart begins again at the pre-charge stage. Deasserting enable turns all outputs off from any state.

Top module: `softstart_sequencer`

## Requirements
- R1: While `enableN` is high, all four outputs are 0 (`limitCode` = 00). From any state, a high `enableN` sampled at a clock edge drives the outputs to 0 after that edge. Reset gives the same all-off state.
- R2: The start-up order and per-stage outputs are fixed as follows. Pre-charge: only `inrushEn`=1. Switch-on: only `switchOn`=1. Boost stages: `switchOn`=1, `lxEn`=1 and `limitCode` = 00, 01, 10 for 25 %, 50 %, 75 %. Normal: `switchOn`=1, `lxEn`=1, `limitCode`=11.
- R3: Pre-charge begins at the first clock edge that samples `enableN` low. With `tick` high every cycle, pre-charge lasts INRUSH_TICKS cycles, switch-on lasts SWITCH_TICKS cycles and each boost stage lasts BOOST_TICKS cycles.
- R4: Stage timers advance only in cycles where `tick` is high. With `tick` low, the current stage holds indefinitely.
- R5: Normal is held for as long as enable stays asserted and no fault flag is raised.
- R6: `uvFault` in any enabled state turns all outputs off at the next edge. The block stays off until `supplyOk` is high while `uvFault` is low, and then re-enters pre-charge.
- R7: `ocFault` in switch-on, any boost stage or normal returns the block to pre-charge at the next edge.
- R8: `ocFault` is ignored during pre-charge.
- R9: `ovFault` turns all outputs off at the next edge. The block waits for `outBelow`, ignoring `tempBelow`, and then re-enters pre-charge.
- R10: `otFault` turns all outputs off at the next edge. The block waits for `tempBelow`, ignoring `outBelow`, and then re-enters pre-charge.
- R11: When faults coincide, the priority is undervoltage, then over-temperature, then overvoltage, then overcurrent. Only undervoltage can end a wait of another class early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableN | input | 1 | Active-low enable |
| tick | input | 1 | Timebase strobe, one cycle wide |
| uvFault | input | 1 | Supply below the power-off level |
| supplyOk | input | 1 | Supply has reached the power-on level |
| ocFault | input | 1 | Input-switch overcurrent |
| ovFault | input | 1 | Output overvoltage |
| outBelow | input | 1 | Output back below the overvoltage threshold |
| otFault | input | 1 | Over-temperature |
| tempBelow | input | 1 | Temperature back below the restart level |
| inrushEn | output | 1 | Input switch in limited-current pre-charge mode |
| switchOn | output | 1 | Input switch fully on |
| lxEn | output | 1 | Switching driver enabled |
| limitCode | output | 2 | Peak current limit scale: 00=25 %, 01=50 %, 10=75 %, 11=100 % |

## Verification
A directed walk with a tick in every cycle pins each stage boundary to the exact cycle, which separates a correct count from an off-by-one count. A walk with the tick held low shows that stalling comes from the tick and not from the clock. Faults are then raised alone, in pairs and with the wrong release flag. These cases separate the correct wait rule and priority from a swapped or missing one, and show that overcurrent is masked only during pre-charge. A long seeded random run uses sparse faults, a gapped tick and occasional enable toggling, and compares the outputs every cycle against a requirement-level model. This catches interactions, such as a fault arriving on the cycle a stage expires.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [3:0] {
    ST_OFF     = 4'd0,
    ST_INRUSH  = 4'd1,
    ST_SWON    = 4'd2,
    ST_BST25   = 4'd3,
    ST_BST50   = 4'd4,
    ST_BST75   = 4'd5,
    ST_NORMAL  = 4'd6,
    ST_WAITUV  = 4'd7,
    ST_WAITOV  = 4'd8,
    ST_WAITOT  = 4'd9
  } seqState_t;

  typedef enum logic [1:0] {
    TM_INRUSH = 2'd0,
    TM_SWON   = 2'd1,
    TM_BOOST  = 2'd2
  } tmSel_t;

  // strobes from control to the stage timer
  typedef struct packed {
    logic   clr;
    logic   run;
    tmSel_t sel;
  } tmStrobe_t;

  typedef struct packed {
    logic uv;
    logic supplyOk;
    logic oc;
    logic ov;
    logic outBelow;
    logic ot;
    logic tempBelow;
  } faultIn_t;

endpackage

// File: rtl/sseq_timer.sv
module sseq_timer
  import sseq_pkg::*;
#(
  parameter int INRUSH_TICKS = 2048,
  parameter int SWITCH_TICKS = 128,
  parameter int BOOST_TICKS  = 2048
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  tmStrobe_t strobe,
  output logic      expire
);

  localparam int MAX_TICKS = (INRUSH_TICKS > BOOST_TICKS)
                           ? ((INRUSH_TICKS > SWITCH_TICKS) ? INRUSH_TICKS : SWITCH_TICKS)
                           : ((BOOST_TICKS > SWITCH_TICKS) ? BOOST_TICKS : SWITCH_TICKS);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lastVal;

  always_comb begin
    case (strobe.sel)
      TM_INRUSH: lastVal = CNT_W'(INRUSH_TICKS - 1);
      TM_SWON:   lastVal = CNT_W'(SWITCH_TICKS - 1);
      TM_BOOST:  lastVal = CNT_W'(BOOST_TICKS - 1);
      default:   lastVal = '0;
    endcase
  end

  assign expire = strobe.run && tick && (cnt == lastVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.clr) begin
      cnt <= '0;
    end else if (strobe.run && tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4: without a tick the stage count must not move
  assert_tick_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clr && !tick) |=> $stable(cnt));

  // R3: a running count never passes the end of its stage
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |-> (cnt <= lastVal));

endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableN,
  input  faultIn_t   fIn,
  input  logic       expire,
  output tmStrobe_t  strobe,
  output logic       inrushEn,
  output logic       switchOn,
  output logic       lxEn,
  output logic [1:0] limitCode
);

  seqState_t curState, nxtState;

  function automatic seqState_t stepAhead(seqState_t s);
    case (s)
      ST_INRUSH: return ST_SWON;
      ST_SWON:   return ST_BST25;
      ST_BST25:  return ST_BST50;
      ST_BST50:  return ST_BST75;
      ST_BST75:  return ST_NORMAL;
      default:   return s;
    endcase
  endfunction

  always_comb begin
    nxtState = curState;
    if (enableN) begin
      nxtState = ST_OFF;
    end else if (curState == ST_OFF) begin
      nxtState = ST_INRUSH;
    end else if (fIn.uv) begin
      nxtState = ST_WAITUV;
    end else begin
      case (curState)
        ST_WAITUV: if (fIn.supplyOk)  nxtState = ST_INRUSH;
        ST_WAITOV: if (fIn.outBelow)  nxtState = ST_INRUSH;
        ST_WAITOT: if (fIn.tempBelow) nxtState = ST_INRUSH;
        default: begin
          if (fIn.ot)                                nxtState = ST_WAITOT;
          else if (fIn.ov)                           nxtState = ST_WAITOV;
          else if (fIn.oc && curState != ST_INRUSH)  nxtState = ST_INRUSH;
          else if (expire)                           nxtState = stepAhead(curState);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_OFF;
    else       curState <= nxtState;
  end

  // timer strobes
  always_comb begin
    strobe.clr = (nxtState != curState);
    strobe.run = (curState >= ST_INRUSH) && (curState <= ST_BST75);
    case (curState)
      ST_INRUSH: strobe.sel = TM_INRUSH;
      ST_SWON:   strobe.sel = TM_SWON;
      default:   strobe.sel = TM_BOOST;
    endcase
  end

  // output decode
  always_comb begin
    inrushEn  = (curState == ST_INRUSH);
    switchOn  = (curState >= ST_SWON) && (curState <= ST_NORMAL);
    lxEn      = (curState >= ST_BST25) && (curState <= ST_NORMAL);
    case (curState)
      ST_BST50:  limitCode = 2'b01;
      ST_BST75:  limitCode = 2'b10;
      ST_NORMAL: limitCode = 2'b11;
      default:   limitCode = 2'b00;
    endcase
  end

  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rstN)
    enableN |=> (curState == ST_OFF));

  assert_lx_after_switch_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lxEn) |-> ($past(curState) == ST_SWON));

  assert_uv_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!enableN && curState != ST_OFF && fIn.uv) |=> (curState == ST_WAITUV));

  assert_oc_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!enableN && !fIn.uv && !fIn.ot && !fIn.ov && fIn.oc &&
     curState >= ST_SWON && curState <= ST_NORMAL) |=> (curState == ST_INRUSH));

  assert_inrush_oc_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_INRUSH && !enableN && !fIn.uv && !fIn.ot && !fIn.ov && !expire)
    |=> (curState == ST_INRUSH));

  assert_ov_wait_R9: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAITOV && !enableN && !fIn.uv && !fIn.outBelow)
    |=> (curState == ST_WAITOV));

  assert_ot_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_WAITOT && !enableN && !fIn.uv && !fIn.tempBelow)
    |=> (curState == ST_WAITOT));

  assert_ot_over_ov_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!enableN && !fIn.uv && fIn.ot && fIn.ov &&
     curState >= ST_INRUSH && curState <= ST_NORMAL) |=> (curState == ST_WAITOT));

endmodule

// File: rtl/softstart_sequencer.sv
module softstart_sequencer
  import sseq_pkg::*;
#(
  parameter int INRUSH_TICKS = 2048,
  parameter int SWITCH_TICKS = 128,
  parameter int BOOST_TICKS  = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enableN,
  input  logic       tick,
  input  logic       uvFault,
  input  logic       supplyOk,
  input  logic       ocFault,
  input  logic       ovFault,
  input  logic       outBelow,
  input  logic       otFault,
  input  logic       tempBelow,
  output logic       inrushEn,
  output logic       switchOn,
  output logic       lxEn,
  output logic [1:0] limitCode
);

  faultIn_t  fIn;
  tmStrobe_t strobe;
  logic      expire;

  assign fIn.uv        = uvFault;
  assign fIn.supplyOk  = supplyOk;
  assign fIn.oc        = ocFault;
  assign fIn.ov        = ovFault;
  assign fIn.outBelow  = outBelow;
  assign fIn.ot        = otFault;
  assign fIn.tempBelow = tempBelow;

  sseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enableN   (enableN),
    .fIn       (fIn),
    .expire    (expire),
    .strobe    (strobe),
    .inrushEn  (inrushEn),
    .switchOn  (switchOn),
    .lxEn      (lxEn),
    .limitCode (limitCode)
  );

  sseq_timer #(
    .INRUSH_TICKS (INRUSH_TICKS),
    .SWITCH_TICKS (SWITCH_TICKS),
    .BOOST_TICKS  (BOOST_TICKS)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .strobe (strobe),
    .expire (expire)
  );

endmodule

// File: tb/softstart_sequencer_test.sv
module softstart_sequencer_test;

  localparam int INR = 12;
  localparam int SWT = 5;
  localparam int BST = 9;

  // expected output words {inrushEn, switchOn, lxEn, limitCode}
  localparam logic [4:0] O_OFF = 5'b00000;
  localparam logic [4:0] O_INR = 5'b10000;
  localparam logic [4:0] O_SW  = 5'b01000;
  localparam logic [4:0] O_B25 = 5'b01100;
  localparam logic [4:0] O_B50 = 5'b01101;
  localparam logic [4:0] O_B75 = 5'b01110;
  localparam logic [4:0] O_NRM = 5'b01111;

  // model stages
  localparam int M_OFF = 0, M_INR = 1, M_SW = 2, M_B25 = 3, M_B50 = 4,
                 M_B75 = 5, M_NRM = 6, M_WUV = 7, M_WOV = 8, M_WOT = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableN = 1'b1, tick = 1'b1;
  logic uvFault = 1'b0, supplyOk = 1'b0, ocFault = 1'b0, ovFault = 1'b0;
  logic outBelow = 1'b0, otFault = 1'b0, tempBelow = 1'b0;
  logic inrushEn, switchOn, lxEn;
  logic [1:0] limitCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  string curReq = "R1";
  int mState = M_OFF;
  int mCnt = 0;

  always #4 clk = ~clk;

  softstart_sequencer #(
    .INRUSH_TICKS (INR), .SWITCH_TICKS (SWT), .BOOST_TICKS (BST)
  ) uut (
    .clk (clk), .rstN (rstN), .enableN (enableN), .tick (tick),
    .uvFault (uvFault), .supplyOk (supplyOk), .ocFault (ocFault),
    .ovFault (ovFault), .outBelow (outBelow), .otFault (otFault),
    .tempBelow (tempBelow), .inrushEn (inrushEn), .switchOn (switchOn),
    .lxEn (lxEn), .limitCode (limitCode)
  );

  function automatic logic [4:0] expOut(int s);
    case (s)
      M_INR:   return O_INR;
      M_SW:    return O_SW;
      M_B25:   return O_B25;
      M_B50:   return O_B50;
      M_B75:   return O_B75;
      M_NRM:   return O_NRM;
      default: return O_OFF;
    endcase
  endfunction

  function automatic int stageLen(int s);
    if (s == M_INR) return INR;
    if (s == M_SW)  return SWT;
    return BST;
  endfunction

  // requirement-level model, stepped at each edge
  always @(posedge clk) begin
    int ns;
    int nc;
    bit timed;
    if (!rstN) begin
      mState <= M_OFF;
      mCnt   <= 0;
    end else begin
      ns = mState;
      timed = (mState >= M_INR) && (mState <= M_B75);
      if (enableN)                ns = M_OFF;
      else if (mState == M_OFF)   ns = M_INR;
      else if (uvFault)           ns = M_WUV;
      else if (mState == M_WUV)   ns = supplyOk  ? M_INR : M_WUV;
      else if (mState == M_WOV)   ns = outBelow  ? M_INR : M_WOV;
      else if (mState == M_WOT)   ns = tempBelow ? M_INR : M_WOT;
      else if (otFault)           ns = M_WOT;
      else if (ovFault)           ns = M_WOV;
      else if (ocFault && mState != M_INR) ns = M_INR;
      else if (timed && tick && mCnt == stageLen(mState) - 1) ns = mState + 1;
      if (ns != mState)        nc = 0;
      else if (timed && tick)  nc = mCnt + 1;
      else                     nc = mCnt;
      mState <= ns;
      mCnt   <= nc;
    end
  end

  task automatic chkOut(string req, logic [4:0] expv);
    logic [4:0] act;
    act = {inrushEn, switchOn, lxEn, limitCode};
    nChecks++;
    if (act !== expv) begin
      nFails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, expv);
    end
  endtask

  // every-cycle comparison against the model (away from the active edge)
  always @(negedge clk) begin
    if (rstN && !finished) chkOut(curReq, expOut(mState));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int guard;
    void'($urandom(32'h5a17));
    // R1: reset and disabled state
    cyc(3);
    chkOut("R1", O_OFF);
    rstN = 1'b1;
    cyc(2);
    chkOut("R1", O_OFF);

    // R2 / R3: full start-up with a tick every cycle
    curReq = "R3";
    enableN = 1'b0;
    for (int n = 1; n <= INR + SWT + 3 * BST + 1; n++) begin
      cyc(1);
      if (n == 1)                     chkOut("R3", O_INR);
      if (n == INR)                   chkOut("R3", O_INR);
      if (n == INR + 1)               chkOut("R2", O_SW);
      if (n == INR + SWT)             chkOut("R3", O_SW);
      if (n == INR + SWT + 1)         chkOut("R2", O_B25);
      if (n == INR + SWT + BST + 1)   chkOut("R2", O_B50);
      if (n == INR + SWT + 2*BST)     chkOut("R3", O_B50);
      if (n == INR + SWT + 2*BST + 1) chkOut("R2", O_B75);
      if (n == INR + SWT + 3*BST + 1) chkOut("R3", O_NRM);
    end

    // R5: normal holds
    curReq = "R5";
    cyc(50);
    chkOut("R5", O_NRM);

    // R1: disable from normal
    curReq = "R1";
    enableN = 1'b1;
    cyc(1);
    chkOut("R1", O_OFF);
    cyc(2);

    // R4: no tick, no progress
    curReq = "R4";
    enableN = 1'b0;
    tick = 1'b0;
    cyc(INR + 6);
    chkOut("R4", O_INR);

    // R8: overcurrent masked in pre-charge
    curReq = "R8";
    tick = 1'b1;
    ocFault = 1'b1;
    cyc(INR - 2);
    chkOut("R8", O_INR);
    ocFault = 1'b0;
    cyc(2);
    chkOut("R2", O_SW);

    // R7: overcurrent after pre-charge restarts
    curReq = "R7";
    ocFault = 1'b1;
    cyc(1);
    chkOut("R7", O_INR);
    ocFault = 1'b0;

    // R9: overvoltage wait
    curReq = "R9";
    guard = 0;
    while (!lxEn && guard < 200) begin cyc(1); guard++; end
    ovFault = 1'b1;
    cyc(1);
    chkOut("R9", O_OFF);
    ovFault = 1'b0;
    tempBelow = 1'b1;
    cyc(4);
    chkOut("R9", O_OFF);
    tempBelow = 1'b0;
    outBelow = 1'b1;
    cyc(1);
    chkOut("R9", O_INR);
    outBelow = 1'b0;

    // R10: over-temperature wait
    curReq = "R10";
    otFault = 1'b1;
    cyc(1);
    chkOut("R10", O_OFF);
    otFault = 1'b0;
    outBelow = 1'b1;
    cyc(3);
    chkOut("R10", O_OFF);
    outBelow = 1'b0;
    tempBelow = 1'b1;
    cyc(1);
    chkOut("R10", O_INR);
    tempBelow = 1'b0;

    // R11 / R6: undervoltage wins over coincident faults
    curReq = "R11";
    uvFault = 1'b1; ovFault = 1'b1; otFault = 1'b1;
    cyc(1);
    chkOut("R6", O_OFF);
    ovFault = 1'b0; otFault = 1'b0;
    outBelow = 1'b1; tempBelow = 1'b1;
    cyc(3);
    chkOut("R11", O_OFF);
    outBelow = 1'b0; tempBelow = 1'b0;
    supplyOk = 1'b1;
    cyc(2);
    chkOut("R6", O_OFF);
    uvFault = 1'b0;
    cyc(1);
    chkOut("R6", O_INR);
    supplyOk = 1'b0;

    // R11: over-temperature wins over overvoltage
    otFault = 1'b1; ovFault = 1'b1;
    cyc(1);
    chkOut("R11", O_OFF);
    otFault = 1'b0; ovFault = 1'b0;
    outBelow = 1'b1;
    cyc(2);
    chkOut("R11", O_OFF);
    outBelow = 1'b0;
    tempBelow = 1'b1;
    cyc(1);
    chkOut("R11", O_INR);
    tempBelow = 1'b0;

    // R11 under load: undervoltage ends an overvoltage wait
    ovFault = 1'b1;
    cyc(1);
    ovFault = 1'b0;
    uvFault = 1'b1;
    cyc(1);
    uvFault = 1'b0;
    outBelow = 1'b1;
    cyc(2);
    chkOut("R11", O_OFF);
    outBelow = 1'b0;

    // random phase, checked every cycle against the model
    curReq = "R2";
    for (int i = 0; i < 6000; i++) begin
      tick      = ($urandom % 4) != 0;
      uvFault   = ($urandom % 400) == 0;
      ocFault   = ($urandom % 300) == 0;
      ovFault   = ($urandom % 300) == 0;
      otFault   = ($urandom % 300) == 0;
      supplyOk  = ($urandom % 15) == 0;
      outBelow  = ($urandom % 15) == 0;
      tempBelow = ($urandom % 15) == 0;
      if (($urandom % 500) == 0) enableN = ~enableN;
      if (enableN && ($urandom % 20) == 0) enableN = 1'b0;
      cyc(1);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule